// File: doc/BRIEF.md
# I2C Target Engine with Programmable Address Match

This block is the target (slave) side of an I2C port. It watches the clock and data lines through a synchronizer, finds Start and Stop conditions in hardware and reports each one. It gathers each byte most-significant bit first and compares the address phase against a programmable own address. It handles 7-bit and 10-bit addressing and can answer the all-zero general-call address. The engine acknowledges matched addresses and accepted data, and it places each received byte in a single buffer register that a processor reads.

For reads from the bus, the engine holds the clock line low until the processor writes the next byte into the buffer. That write loads the transmit shift register in the same cycle, so transmission has no second buffer. Reception is double-buffered: bits build up in a hidden shift register and are copied to the buffer only when the byte is complete. Both lines are open drain, so the engine never drives a line high. It only raises a drive-low enable for each line.

The processor side sees a buffer port, a status byte and a one-cycle event pulse. The pulse fires on Start, Stop, an accepted address, a completed received byte (stored or rejected) and the end of each transmitted byte.

Top module: `i2c_target_engine`

## Requirements
- R1: A Start (SDA falls while SCL stays high) sets status bit 3 and clears bit 4. A Stop (SDA rises while SCL stays high) sets bit 4 and clears bits 3 and 2. Each of these events raises `event_pulse` for one cycle. After a Stop the engine drives neither line.
- R2: When `addr10_mode` is 0, an address byte whose upper seven bits equal `own_addr[6:0]` is acknowledged (SDA low during the ninth clock). Any other byte is not acknowledged, and the engine then ignores the bus until the next Start or Stop.
- R3: When `addr10_mode` is 1, a first byte of binary 11110, then `own_addr[9:8]`, then R/W=0 is acknowledged. The byte after it is acknowledged only if it equals `own_addr[7:0]`. On a mismatch it is not acknowledged and the engine ignores the bus.
- R4: In 10-bit mode, a first byte with R/W=1 is acknowledged only after a repeated Start that follows a full two-byte match. The match is forgotten at a Stop. Without a match the byte is not acknowledged.
- R5: The byte 0x00 is accepted as a write address only while `gcall_en` is 1. Otherwise it is not acknowledged.
- R6: Data bits arrive MSB first on SCL rising edges. Each completed byte written to a matched engine is acknowledged, copied to `buf_data`, and sets status bit 0 (buffer full) and bit 5 (last byte was data). A one-cycle `buf_rd` clears bit 0.
- R7: If a data byte completes while bit 0 is set, the engine does not acknowledge it, sets status bit 1 (overflow) and keeps the old `buf_data`. A one-cycle `ovf_clr` clears bit 1.
- R8: After an accepted address with R/W=1, status bit 2 is set and the engine holds SCL low until `buf_wr`. That write loads the buffer and the transmit shifter together and releases SCL. The byte is then sent MSB first.
- R9: If the bus master acknowledges a transmitted byte, the engine stretches SCL again for the next byte. If it does not acknowledge, the engine releases both lines and ignores the bus until a Start or Stop.
- R10: A Start in the middle of any byte abandons that byte. Nothing is stored, and the engine begins a new address phase.
- R11: The status byte is `{sw[1:0], data_last, stop, start, read, overflow, full}` from bit 7 down to bit 0. Only the top two bits can be written, through `stat_wr` with `stat_sw_wdata`. The lower six bits ignore that write.
- R12: After reset the status byte, `buf_data` and both drive-low enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sensed level of the clock line |
| sda_in | input | 1 | Sensed level of the data line |
| scl_drive_low | output | 1 | Pull the clock line low (stretching) |
| sda_drive_low | output | 1 | Pull the data line low (ACK or a zero bit) |
| own_addr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| addr10_mode | input | 1 | 1 selects 10-bit addressing |
| gcall_en | input | 1 | 1 accepts the general-call address |
| buf_wr | input | 1 | Write strobe for the buffer (and the transmit shifter while stretching) |
| buf_wdata | input | 8 | Byte to write into the buffer |
| buf_rd | input | 1 | Read strobe; clears the buffer-full flag |
| buf_data | output | 8 | Current buffer contents |
| ovf_clr | input | 1 | Clears the overflow flag |
| stat_wr | input | 1 | Write strobe for the two software status bits |
| stat_sw_wdata | input | 2 | New value for status bits 7:6 |
| stat | output | 8 | Status byte |
| event_pulse | output | 1 | One-cycle interrupt event |

## Verification
The assertions take for granted a well-formed bus. SDA changes only while SCL is low, except where a Start or Stop is meant. Each SCL level lasts far longer than the three-cycle synchronizer delay. The processor writes the buffer only while the engine is stretching or idle. The bench's master model keeps to these rules. It sets every line change on a falling system-clock edge, holds each SCL phase for ten or more cycles, and always waits for the clock line to read high before it times the high phase. Stretching therefore cannot shorten a bit, and the processor model writes the buffer only after it sees `scl_drive_low` asserted.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_LO,
        ST_RX,
        ST_ACK,
        ST_TX_HOLD,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] raw;
    logic [1:0] synced;
    logic [1:0] prev;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe    <= '1;
                prev[g] <= 1'b1;
            end else begin
                pipe    <= {pipe[SYNC_STAGES-2:0], raw[g]};
                prev[g] <= pipe[SYNC_STAGES-1];
            end
        end
        assign synced[g] = pipe[SYNC_STAGES-1];
    end

    assign sda_s    = synced[1];
    assign scl_rise = synced[0] & ~prev[0];
    assign scl_fall = ~synced[0] & prev[0];
    assign start_ev = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_ev  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/i2c_tgt_addrcmp.sv
module i2c_tgt_addrcmp
    import i2c_tgt_pkg::*;
(
    input  logic [BYTE_W-1:0] cand,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              addr10_mode,
    input  logic              gcall_en,
    input  logic              ten_armed,
    output logic              hit_rx,
    output logic              hit_tx,
    output logic              hit_hdr,
    output logic              hit_lo
);
    localparam logic [4:0] HDR_TAG = 5'b11110;

    logic gc, a7, hdr;

    always_comb begin
        gc      = gcall_en && (cand == '0);
        a7      = !addr10_mode && (cand[BYTE_W-1:1] == own_addr[6:0]);
        hdr     = addr10_mode && (cand[7:3] == HDR_TAG) && (cand[2:1] == own_addr[9:8]);
        hit_rx  = gc || (a7 && !cand[0]);
        hit_tx  = (a7 && cand[0]) || (hdr && cand[0] && ten_armed);
        hit_hdr = hdr && !cand[0];
        hit_lo  = (cand == own_addr[BYTE_W-1:0]);
    end
endmodule

// File: rtl/i2c_tgt_bytefsm.sv
module i2c_tgt_bytefsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              buf_full,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              hit_rx,
    input  logic              hit_tx,
    input  logic              hit_hdr,
    input  logic              hit_lo,
    output logic [BYTE_W-1:0] shift_byte,
    output logic              ten_armed,
    output logic              scl_low,
    output logic              sda_low,
    output logic              ev_addr,
    output logic              ev_rw,
    output logic              ev_store,
    output logic              ev_ovf,
    output logic              ev_txdone
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    tgt_state_e        state, nxt, dest;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr;
    logic [1:0]        ph;
    logic              ack_en, mack;
    logic              full_byte;

    assign shift_byte = sr;
    assign full_byte  = (cnt == CNT_FULL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions and event strobes
    always_comb begin
        nxt       = state;
        ev_addr   = 1'b0;
        ev_rw     = 1'b0;
        ev_store  = 1'b0;
        ev_ovf    = 1'b0;
        ev_txdone = 1'b0;
        if (start_ev) begin
            nxt = ST_ADDR;
        end else if (stop_ev) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: if (full_byte) begin
                    nxt     = (hit_rx || hit_tx || hit_hdr) ? ST_ACK : ST_SKIP;
                    ev_addr = hit_rx || hit_tx;
                    ev_rw   = hit_tx;
                end
                ST_ADDR_LO: if (full_byte) begin
                    nxt     = hit_lo ? ST_ACK : ST_SKIP;
                    ev_addr = hit_lo;
                end
                ST_RX: if (full_byte) begin
                    nxt      = ST_ACK;
                    ev_store = !buf_full;
                    ev_ovf   = buf_full;
                end
                ST_ACK:     if (ph == 2'd2 && scl_fall) nxt = dest;
                ST_TX_HOLD: if (tx_load) nxt = ST_TX;
                ST_TX:      if (scl_fall && cnt == CNT_LAST) nxt = ST_TX_ACK;
                ST_TX_ACK: if (ph == 2'd1 && scl_fall) begin
                    nxt       = mack ? ST_TX_HOLD : ST_SKIP;
                    ev_txdone = 1'b1;
                end
                ST_SKIP: nxt = ST_SKIP;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            sr        <= '0;
            ph        <= '0;
            ack_en    <= 1'b0;
            mack      <= 1'b0;
            dest      <= ST_IDLE;
            ten_armed <= 1'b0;
        end else if (start_ev) begin
            cnt <= '0;
            ph  <= '0;
        end else if (stop_ev) begin
            cnt       <= '0;
            ph        <= '0;
            ten_armed <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_ADDR_LO, ST_RX: begin
                    if (scl_rise && !full_byte) begin
                        sr  <= {sr[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end
                    if (full_byte) begin
                        cnt <= '0;
                        ph  <= '0;
                        if (state == ST_ADDR) begin
                            ack_en <= 1'b1;
                            dest   <= hit_tx ? ST_TX_HOLD : (hit_hdr ? ST_ADDR_LO : ST_RX);
                        end else if (state == ST_ADDR_LO) begin
                            ack_en <= 1'b1;
                            dest   <= ST_RX;
                            if (hit_lo) ten_armed <= 1'b1;
                        end else begin
                            ack_en <= !buf_full;
                            dest   <= ST_RX;
                        end
                    end
                end
                ST_ACK: begin
                    if (ph == 2'd0 && scl_fall)      ph <= 2'd1;
                    else if (ph == 2'd1 && scl_rise) ph <= 2'd2;
                    else if (ph == 2'd2 && scl_fall) ph <= 2'd0;
                end
                ST_TX_HOLD: if (tx_load) begin
                    sr  <= tx_byte;
                    cnt <= '0;
                    ph  <= '0;
                end
                ST_TX: if (scl_fall) begin
                    sr  <= {sr[BYTE_W-2:0], 1'b1};
                    cnt <= cnt + 1'b1;
                end
                ST_TX_ACK: begin
                    if (ph == 2'd0 && scl_rise) begin
                        mack <= !sda_s;
                        ph   <= 2'd1;
                    end else if (ph == 2'd1 && scl_fall) begin
                        ph <= 2'd0;
                    end
                end
                default: ;
            endcase
        end
    end

    // line outputs
    always_comb begin
        scl_low = (state == ST_TX_HOLD);
        sda_low = 1'b0;
        unique case (state)
            ST_ACK:  sda_low = ack_en && (ph != 2'd0);
            ST_TX:   sda_low = !sr[BYTE_W-1];
            default: sda_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              addr10_mode,
    input  logic              gcall_en,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_rd,
    output logic [BYTE_W-1:0] buf_data,
    input  logic              ovf_clr,
    input  logic              stat_wr,
    input  logic [1:0]        stat_sw_wdata,
    output logic [7:0]        stat,
    output logic              event_pulse
);
    logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              hit_rx, hit_tx, hit_hdr, hit_lo, ten_armed;
    logic [BYTE_W-1:0] shift_byte;
    logic              ev_addr, ev_rw, ev_store, ev_ovf, ev_txdone;
    logic              f_full, f_ovf, f_read, f_start, f_stop, f_data;
    logic [1:0]        sw_bits;
    logic [BYTE_W-1:0] dbuf;

    i2c_tgt_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2c_tgt_addrcmp u_cmp (
        .cand(shift_byte), .own_addr(own_addr), .addr10_mode(addr10_mode),
        .gcall_en(gcall_en), .ten_armed(ten_armed),
        .hit_rx(hit_rx), .hit_tx(hit_tx), .hit_hdr(hit_hdr), .hit_lo(hit_lo)
    );

    i2c_tgt_bytefsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .buf_full(f_full), .tx_load(buf_wr), .tx_byte(buf_wdata),
        .hit_rx(hit_rx), .hit_tx(hit_tx), .hit_hdr(hit_hdr), .hit_lo(hit_lo),
        .shift_byte(shift_byte), .ten_armed(ten_armed),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low),
        .ev_addr(ev_addr), .ev_rw(ev_rw), .ev_store(ev_store),
        .ev_ovf(ev_ovf), .ev_txdone(ev_txdone)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbuf        <= '0;
            f_full      <= 1'b0;
            f_ovf       <= 1'b0;
            f_read      <= 1'b0;
            f_start     <= 1'b0;
            f_stop      <= 1'b0;
            f_data      <= 1'b0;
            sw_bits     <= '0;
            event_pulse <= 1'b0;
        end else begin
            event_pulse <= start_ev | stop_ev | ev_addr | ev_store | ev_ovf | ev_txdone;
            if (start_ev) begin
                f_start <= 1'b1;
                f_stop  <= 1'b0;
            end
            if (stop_ev) begin
                f_stop  <= 1'b1;
                f_start <= 1'b0;
                f_read  <= 1'b0;
            end
            if (ev_addr) begin
                f_read <= ev_rw;
                f_data <= 1'b0;
            end
            if (buf_wr) dbuf <= buf_wdata;
            if (buf_rd) f_full <= 1'b0;
            if (ev_store) begin
                dbuf   <= shift_byte;
                f_full <= 1'b1;
                f_data <= 1'b1;
            end
            if (ev_ovf)       f_ovf <= 1'b1;
            else if (ovf_clr) f_ovf <= 1'b0;
            if (stat_wr) sw_bits <= stat_sw_wdata;
        end
    end

    assign buf_data = dbuf;
    assign stat     = {sw_bits, f_data, f_stop, f_start, f_read, f_ovf, f_full};
endmodule

// File: rtl/i2c_target_engine_chk.sv
module i2c_target_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_drive_low,
    input logic       sda_drive_low,
    input logic       buf_wr,
    input logic       buf_rd,
    input logic [7:0] buf_data,
    input logic       stat_wr,
    input logic [1:0] stat_sw_wdata,
    input logic [7:0] stat,
    input logic       event_pulse
);
    AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(stat[3] && stat[4])); // R1
    AST_START_EVENT: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat[3]) |-> event_pulse); // R1
    AST_QUIET_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n) stat[4] |-> (!scl_drive_low && !sda_drive_low)); // R1
    AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat[1]) |-> stat[0]); // R7
    AST_FULL_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n) (stat[0] && !buf_rd && !buf_wr) |=> $stable(buf_data)); // R7
    AST_STRETCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (scl_drive_low && buf_wr) |=> !scl_drive_low); // R8
    AST_STRETCH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) scl_drive_low |-> stat[2]); // R8
    AST_SW_BITS: assert property (@(posedge clk) disable iff (!rst_n) stat_wr |=> (stat[7:6] == $past(stat_sw_wdata))); // R11
endmodule

bind i2c_target_engine i2c_target_engine_chk u_chk (.*);

// File: tb/i2c_target_engine_test.sv
module i2c_target_engine_test;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_bus, sda_bus;
    logic       scl_drive_low, sda_drive_low;
    logic [9:0] own_addr = 10'h02A;
    logic       addr10_mode = 1'b0, gcall_en = 1'b0;
    logic       buf_wr = 1'b0, buf_rd = 1'b0, ovf_clr = 1'b0, stat_wr = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic [1:0] stat_sw_wdata = '0;
    logic [7:0] buf_data, stat;
    logic       event_pulse;
    int         checks = 0, errors = 0, ev_cnt = 0, cyc = 0;

    always #5 clk = ~clk;

    assign scl_bus = scl_m & ~scl_drive_low;
    assign sda_bus = sda_m & ~sda_drive_low;

    i2c_target_engine uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .own_addr(own_addr), .addr10_mode(addr10_mode), .gcall_en(gcall_en),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd),
        .buf_data(buf_data), .ovf_clr(ovf_clr), .stat_wr(stat_wr),
        .stat_sw_wdata(stat_sw_wdata), .stat(stat), .event_pulse(event_pulse)
    );

    always @(posedge clk) begin
        cyc++;
        if (event_pulse) ev_cnt++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (scl_bus !== 1'b1) tick(1);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(Q);
        b = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(nack);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            b[i] = x;
        end
        put_bit(!give_ack);
    endtask

    task automatic sw_feed(input logic [7:0] b, input string tag);
        while (scl_drive_low !== 1'b1) tick(1);
        tick(4);
        chk({tag, " clock held low while waiting"}, scl_bus, 1'b0);
        buf_wdata = b; buf_wr = 1'b1; tick(1); buf_wr = 1'b0;
        chk({tag, " clock released after buffer write"}, scl_drive_low, 1'b0);
    endtask

    task automatic sw_read();
        buf_rd = 1'b1; tick(1); buf_rd = 1'b0;
    endtask

    initial begin
        logic       nk;
        logic [7:0] rb;
        int         e0;
        tick(3);
        // R12 reset state
        chk("R12 status after reset", stat, 8'h00);
        chk("R12 buffer after reset", buf_data, 8'h00);
        chk("R12 drives after reset", {scl_drive_low, sda_drive_low}, 2'b00);
        rst_n = 1'b1; tick(5);

        // R1 start detection and event, R2 / R6 seven-bit write
        e0 = ev_cnt;
        bus_start();
        chk("R1 start sets bit3 clears bit4", stat[4:3], 2'b01);
        chk("R1 one event on start", ev_cnt - e0, 1);
        send_byte({7'h2A, 1'b0}, nk);
        chk("R2 matching 7-bit address acked", nk, 1'b0);
        send_byte(8'hA5, nk);
        chk("R6 data acked", nk, 1'b0);
        chk("R6 buffer holds byte", buf_data, 8'hA5);
        chk("R6 full and data flags", {stat[5], stat[0]}, 2'b11);
        sw_read();
        chk("R6 read clears full", stat[0], 1'b0);
        send_byte(8'h3C, nk);
        chk("R6 second byte MSB first", buf_data, 8'h3C);
        sw_read();
        bus_stop();
        chk("R1 stop sets bit4 clears bit3", stat[4:3], 2'b10);

        // R2 mismatch ignored
        bus_start();
        send_byte({7'h2B, 1'b0}, nk);
        chk("R2 other address not acked", nk, 1'b1);
        send_byte(8'h77, nk);
        chk("R2 data after mismatch not acked", nk, 1'b1);
        chk("R2 buffer untouched after mismatch", {stat[0], buf_data}, {1'b0, 8'h3C});
        bus_stop();

        // R7 overflow
        bus_start();
        send_byte({7'h2A, 1'b0}, nk);
        send_byte(8'h11, nk);
        chk("R7 first byte acked", nk, 1'b0);
        send_byte(8'h22, nk);
        chk("R7 overflow byte not acked", nk, 1'b1);
        chk("R7 overflow flag set", stat[1], 1'b1);
        chk("R7 old byte kept", buf_data, 8'h11);
        ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
        chk("R7 overflow cleared", stat[1], 1'b0);
        sw_read();
        bus_stop();

        // R5 general call
        bus_start();
        send_byte(8'h00, nk);
        chk("R5 general call refused when disabled", nk, 1'b1);
        bus_stop();
        gcall_en = 1'b1;
        bus_start();
        send_byte(8'h00, nk);
        chk("R5 general call acked when enabled", nk, 1'b0);
        send_byte(8'h5E, nk);
        chk("R5 general call data stored", buf_data, 8'h5E);
        sw_read();
        bus_stop();
        gcall_en = 1'b0;

        // R8 / R9 seven-bit read with stretching
        bus_start();
        send_byte({7'h2A, 1'b1}, nk);
        chk("R8 read address acked", nk, 1'b0);
        chk("R8 read flag set", stat[2], 1'b1);
        fork
            sw_feed(8'hC3, "R8 first byte");
            recv_byte(1'b1, rb);
        join
        chk("R8 transmitted byte MSB first", rb, 8'hC3);
        fork
            sw_feed(8'h5A, "R9 stretch again after master ack");
            recv_byte(1'b0, rb);
        join
        chk("R9 second transmitted byte", rb, 8'h5A);
        tick(Q);
        chk("R9 lines free after master nack", {scl_drive_low, sda_drive_low}, 2'b00);
        bus_stop();

        // R10 start in mid-byte aborts it
        bus_start();
        send_byte({7'h2A, 1'b0}, nk);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        chk("R10 partial byte not stored", stat[0], 1'b0);
        send_byte({7'h2A, 1'b0}, nk);
        chk("R10 address after repeated start acked", nk, 1'b0);
        send_byte(8'h42, nk);
        chk("R10 fresh byte stored", buf_data, 8'h42);
        sw_read();
        bus_stop();

        // R3 / R4 ten-bit addressing, own address 0x2D3
        addr10_mode = 1'b1; own_addr = 10'h2D3;
        bus_start();
        send_byte(8'hF5, nk);
        chk("R4 read header refused without prior match", nk, 1'b1);
        bus_stop();
        bus_start();
        send_byte(8'hF4, nk);
        chk("R3 header acked", nk, 1'b0);
        send_byte(8'hD4, nk);
        chk("R3 wrong low byte not acked", nk, 1'b1);
        bus_stop();
        bus_start();
        send_byte(8'hF4, nk);
        send_byte(8'hD3, nk);
        chk("R3 low byte acked", nk, 1'b0);
        send_byte(8'h77, nk);
        chk("R3 ten-bit data stored", buf_data, 8'h77);
        sw_read();
        bus_start();
        send_byte(8'hF5, nk);
        chk("R4 read header acked after match", nk, 1'b0);
        fork
            sw_feed(8'h99, "R4 ten-bit read");
            recv_byte(1'b0, rb);
        join
        chk("R4 ten-bit read byte", rb, 8'h99);
        bus_stop();

        // R11 status write reaches only the top two bits
        rb = stat;
        stat_sw_wdata = 2'b11; stat_wr = 1'b1; tick(1); stat_wr = 1'b0;
        chk("R11 software bits written", stat[7:6], 2'b11);
        chk("R11 hardware bits unchanged", stat[5:0], rb[5:0]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule